// File: doc/BRIEF.md
# Serial Buffer-Access Slave with Wrapping Address

This block lets an external serial master read and write bytes in on-chip packet buffers. The master lowers chip select and sends a frame. The frame starts with a two-byte buffer address, sent high byte first, then low byte. A control byte follows, naming the buffer block, the direction and the transfer mode. After that come as many data bytes as the master chooses to clock. The block turns each data byte into one access on a synchronous byte-wide memory port with a block select. It then steps a 16-bit address.

The address runs through the full 16-bit space of the selected buffer. When a burst passes 0xFFFF it carries on at 0x0000 in the same frame, with no second header. A DMA engine on the master side therefore sees one unbroken payload, even across the top of the buffer.

The serial pins are sampled by a synchronizer in the `clk` domain. Timing limits for the master:
- Each SCLK level must last at least six `clk` cycles.
- Chip select must stay high for at least eight `clk` cycles between frames.

The memory port returns read data one cycle after `mem_rd`.

Top module: `spi_wrap_slave`

## Requirements
- R1: After reset, `mem_wr` and `mem_rd` are low. `spi_miso_oe` is low while `spi_cs_n` is high.
- R2: The link uses SPI mode 0, MSB first. Within a frame:
  - byte 0 is address bits [15:8];
  - byte 1 is address bits [7:0];
  - byte 2 is the control byte: bits [7:3] are the block, bit 2 is 1 for write and 0 for read, and bits [1:0] must be 00.
  - A read frame never pulses `mem_wr`.
- R3: In a write frame, each complete data byte gives exactly one single-cycle `mem_wr` pulse. That pulse carries the selected block, the current address and the byte. The address then rises by one.
- R4: In a read frame, data byte k on MISO is the memory content at header address + k, for the selected block.
  - Each byte is fetched with a one-cycle `mem_rd` pulse before its first bit is due.
  - A frame of n data bytes issues n+1 reads; the last one is a prefetch.
- R5: The address after 0xFFFF is 0x0000 within the same frame, for reads and for writes alike.
- R6: MISO is 0 during the three header bytes. `spi_miso_oe` is high while `spi_cs_n` is low and low once it returns high.
- R7: If control bits [1:0] are not 00, the frame is dropped: no `mem_wr` and no `mem_rd` until the next frame.
- R8: Raising `spi_cs_n` ends the frame at any bit.
  - A partly received byte is discarded and causes no write.
  - The next frame is parsed from its address high byte.
  - A few cycles after `spi_cs_n` rises, no memory access occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from master |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| mem_blk | output | 5 | Buffer block select |
| mem_addr | output | 16 | Buffer byte address |
| mem_wr | output | 1 | Single-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Single-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
Each SCLK edge reaches the frame logic three `clk` cycles after it happens on the pin: two synchronizer stages plus one state register.
- A write strobe therefore appears about three cycles after the eighth rising edge of a byte.
- A read byte is loaded into the shifter two cycles after that: one cycle for the strobe, one for memory latency.

The bench holds each SCLK level for eight cycles. It samples MISO just before each rising edge and checks memory accesses only after chip select has risen at the end of a frame. Every result has therefore settled by the time it is compared.

// File: rtl/spi_wrap_pkg.sv
package spi_wrap_pkg;

    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int BLK_W     = 5;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int BLK_LSB   = BYTE_W - BLK_W;   // control field: block in the top bits
    localparam int DIR_BIT   = 2;                // control field: 1 = write
    localparam logic [1:0] MODE_VAR = 2'b00;     // variable-length burst

    typedef enum logic [2:0] {
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_CTRL,
        PH_DATA,
        PH_DROP
    } phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic                   sclk_prev;
        logic [BIT_CNT_W-1:0]   bitcnt;
        logic [BYTE_W-1:0]      rx;
        logic [BYTE_W-1:0]      tx;
        logic [ADDR_W-1:0]      addr;
        logic [BLK_W-1:0]       blk;
        logic                   is_wr;
        logic                   mem_wr;
        logic                   mem_rd;
        logic                   rd_lat;
        logic [ADDR_W-1:0]      mem_addr;
        logic [BYTE_W-1:0]      mem_wdata;
    } frame_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= RST_VAL;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= {STAGES{RST_VAL}};
                else        stage_q <= {stage_q[STAGES-2:0], d};
            end
            assign q = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_wrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              cs_act_s,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BLK_W-1:0]  mem_blk,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              miso_bit
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    frame_state_t st_q, st_d;

    logic              sclk_rise;
    logic              sclk_fall;
    logic [BYTE_W-1:0] byte_in;

    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign sclk_fall = ~sclk_s & st_q.sclk_prev;
    assign byte_in   = {st_q.rx[BYTE_W-2:0], mosi_s};

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.mem_wr    = 1'b0;
        st_d.mem_rd    = 1'b0;
        st_d.rd_lat    = st_q.mem_rd;

        if (!cs_act_s) begin
            st_d.phase  = PH_ADDR_HI;
            st_d.bitcnt = '0;
            st_d.rx     = '0;
            st_d.tx     = '0;
        end else begin
            // MISO advances on falling edges inside a byte only
            if (sclk_fall && st_q.bitcnt != '0) begin
                st_d.tx = {st_q.tx[BYTE_W-2:0], 1'b0};
            end
            // fetched byte arrives one cycle after the read strobe
            if (st_q.rd_lat) begin
                st_d.tx = mem_rdata;
            end
            if (sclk_rise) begin
                st_d.rx     = byte_in;
                st_d.bitcnt = st_q.bitcnt + BIT_CNT_W'(1);
                if (st_q.bitcnt == LAST_BIT) begin
                    unique case (st_q.phase)
                        PH_ADDR_HI: begin
                            st_d.addr[ADDR_W-1:BYTE_W] = byte_in;
                            st_d.phase = PH_ADDR_LO;
                        end
                        PH_ADDR_LO: begin
                            st_d.addr[BYTE_W-1:0] = byte_in;
                            st_d.phase = PH_CTRL;
                        end
                        PH_CTRL: begin
                            st_d.blk   = byte_in[BYTE_W-1:BLK_LSB];
                            st_d.is_wr = byte_in[DIR_BIT];
                            if (byte_in[1:0] != MODE_VAR) begin
                                st_d.phase = PH_DROP;
                            end else begin
                                st_d.phase = PH_DATA;
                                if (!byte_in[DIR_BIT]) begin
                                    st_d.mem_rd   = 1'b1;
                                    st_d.mem_addr = st_q.addr;
                                    st_d.addr     = st_q.addr + ADDR_W'(1);
                                end
                            end
                        end
                        PH_DATA: begin
                            st_d.mem_addr = st_q.addr;
                            st_d.addr     = st_q.addr + ADDR_W'(1);
                            if (st_q.is_wr) begin
                                st_d.mem_wr    = 1'b1;
                                st_d.mem_wdata = byte_in;
                            end else begin
                                st_d.mem_rd    = 1'b1;
                            end
                        end
                        default: begin
                            st_d.phase = PH_DROP;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_ADDR_HI, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_blk   = st_q.blk;
    assign mem_addr  = st_q.mem_addr;
    assign mem_wr    = st_q.mem_wr;
    assign mem_wdata = st_q.mem_wdata;
    assign mem_rd    = st_q.mem_rd;
    assign miso_bit  = st_q.tx[BYTE_W-1];

endmodule

// File: rtl/spi_wrap_slave.sv
module spi_wrap_slave
    import spi_wrap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [BLK_W-1:0]  mem_blk,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_rd,
    input  logic [BYTE_W-1:0] mem_rdata
);

    logic [2:0] pins_s;

    spi_pin_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sclk, spi_mosi}),
        .q     (pins_s)
    );

    spi_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .cs_act_s  (~pins_s[2]),
        .mem_rdata (mem_rdata),
        .mem_blk   (mem_blk),
        .mem_addr  (mem_addr),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .miso_bit  (spi_miso)
    );

    // pad driver is released as soon as the master deselects
    assign spi_miso_oe = ~spi_cs_n;

endmodule

// File: rtl/spi_wrap_slave_chk.sv
module spi_wrap_slave_chk
    import spi_wrap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr
);

    logic [3:0]        hi_cnt;
    logic              wr_seen, rd_seen;
    logic [ADDR_W-1:0] last_wr, last_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            wr_seen <= 1'b0;
            rd_seen <= 1'b0;
            last_wr <= '0;
            last_rd <= '0;
        end else begin
            if (!spi_cs_n)             hi_cnt <= '0;
            else if (hi_cnt != 4'hF)   hi_cnt <= hi_cnt + 4'd1;
            if (spi_cs_n && hi_cnt >= 4'd5) begin
                wr_seen <= 1'b0;
                rd_seen <= 1'b0;
            end else begin
                if (mem_wr) begin wr_seen <= 1'b1; last_wr <= mem_addr; end
                if (mem_rd) begin rd_seen <= 1'b1; last_rd <= mem_addr; end
            end
        end
    end

    assert_wr_rd_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    assert_wr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && wr_seen) |-> (mem_addr == ADDR_W'(last_wr + ADDR_W'(1))));

    assert_rd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && rd_seen) |-> (mem_addr == ADDR_W'(last_rd + ADDR_W'(1))));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= 4'd6) |-> !(mem_wr || mem_rd));

endmodule

bind spi_wrap_slave spi_wrap_slave_chk u_chk (.*);

// File: tb/spi_wrap_slave_test.sv
module spi_wrap_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int MAX_CYC    = 100000;

    typedef struct packed {
        logic        wr;
        logic [4:0]  blk;
        logic [15:0] addr;
        logic [4:0]  n;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd3,  16'h1234, 5'd4, 8'hA0},
        '{1'b0, 5'd5,  16'h0100, 5'd4, 8'h00},
        '{1'b0, 5'd1,  16'hFFFC, 5'd8, 8'h00},
        '{1'b1, 5'd31, 16'hFFFE, 5'd5, 8'h10},
        '{1'b0, 5'd0,  16'h7FFF, 5'd3, 8'h00},
        '{1'b1, 5'd0,  16'h0000, 5'd1, 8'h5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic [4:0]  mem_blk;
    logic [15:0] mem_addr;
    logic        mem_wr, mem_rd;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    int wcnt = 0;
    int rcnt = 0;
    logic        done = 1'b0;
    logic [4:0]  wlog_blk  [0:63];
    logic [15:0] wlog_addr [0:63];
    logic [7:0]  wlog_data [0:63];
    logic [7:0]  rbuf [0:31];
    logic [7:0]  hdr_or;
    logic        oe_in_frame;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_wrap_slave uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .mem_blk(mem_blk), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] model(input logic [4:0] b, input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ {b, 3'b101};
    endfunction

    // buffer memory model and access log
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= model(mem_blk, mem_addr);
            rcnt <= rcnt + 1;
        end
        if (mem_wr) begin
            wlog_blk[wcnt & 63]  <= mem_blk;
            wlog_addr[wcnt & 63] <= mem_addr;
            wlog_data[wcnt & 63] <= mem_wdata;
            wcnt <= wcnt + 1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        oe_in_frame = spi_miso_oe;
    endtask

    task automatic cs_high();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic run_frame(input logic [15:0] a, input logic [7:0] ctrl, input int n, input logic [7:0] seed);
        logic [7:0] h0, h1, h2;
        cs_low();
        xfer(a[15:8], 8, h0);
        xfer(a[7:0], 8, h1);
        xfer(ctrl, 8, h2);
        hdr_or = h0 | h1 | h2;
        for (int i = 0; i < n; i++) begin
            logic [7:0] r;
            xfer(seed + 8'(i), 8, r);
            rbuf[i] = r;
        end
        cs_high();
    endtask

    initial begin
        int wbase, rbase;
        logic [7:0] junk;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(mem_wr == 1'b0, "R1 wr low in reset", 32'(mem_wr), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(mem_wr == 1'b0, "R1 wr idle", 32'(mem_wr), 0);
        check(mem_rd == 1'b0, "R1 rd idle", 32'(mem_rd), 0);
        check(spi_miso_oe == 1'b0, "R1 oe idle", 32'(spi_miso_oe), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            wbase = wcnt;
            rbase = rcnt;
            run_frame(t.addr, {t.blk, t.wr, 2'b00}, int'(t.n), t.seed);
            check(hdr_or == 8'h00, "R6 header MISO zero", 32'(hdr_or), 0);
            check(oe_in_frame == 1'b1, "R6 oe in frame", 32'(oe_in_frame), 1);
            check(spi_miso_oe == 1'b0, "R6 oe after frame", 32'(spi_miso_oe), 0);
            if (t.wr) begin
                check(wcnt == wbase + int'(t.n), "R3 write count", 32'(wcnt - wbase), 32'(t.n));
                for (int i = 0; i < int'(t.n); i++) begin
                    int k;
                    logic [15:0] ea;
                    k  = (wbase + i) & 63;
                    ea = t.addr + 16'(i);
                    check(wlog_addr[k] == ea, "R3 R5 write address", 32'(wlog_addr[k]), 32'(ea));
                    check(wlog_data[k] == t.seed + 8'(i), "R3 write data", 32'(wlog_data[k]), 32'(t.seed + 8'(i)));
                    check(wlog_blk[k] == t.blk, "R2 write block", 32'(wlog_blk[k]), 32'(t.blk));
                end
            end else begin
                check(wcnt == wbase, "R2 read frame no write", 32'(wcnt - wbase), 0);
                check(rcnt == rbase + int'(t.n) + 1, "R4 read count", 32'(rcnt - rbase), 32'(int'(t.n) + 1));
                for (int i = 0; i < int'(t.n); i++) begin
                    logic [7:0] e;
                    e = model(t.blk, t.addr + 16'(i));
                    check(rbuf[i] == e, "R4 R5 read data", 32'(rbuf[i]), 32'(e));
                end
            end
        end

        // R7: non-variable mode write and read frames are dropped
        wbase = wcnt;
        rbase = rcnt;
        run_frame(16'h2000, {5'd2, 1'b1, 2'b01}, 3, 8'h33);
        run_frame(16'h2100, {5'd2, 1'b0, 2'b10}, 2, 8'h00);
        check(wcnt == wbase, "R7 dropped frame writes", 32'(wcnt - wbase), 0);
        check(rcnt == rbase, "R7 dropped frame reads", 32'(rcnt - rbase), 0);

        // R8: abort mid-byte, partial byte discarded
        wbase = wcnt;
        cs_low();
        xfer(8'h40, 8, junk);
        xfer(8'h00, 8, junk);
        xfer({5'd7, 1'b1, 2'b00}, 8, junk);
        xfer(8'h11, 8, junk);
        xfer(8'hF0, 4, junk);
        cs_high();
        check(wcnt == wbase + 1, "R8 abort write count", 32'(wcnt - wbase), 1);
        check(wlog_data[wbase & 63] == 8'h11, "R8 full byte kept", 32'(wlog_data[wbase & 63]), 32'h11);
        check(wlog_addr[wbase & 63] == 16'h4000, "R8 full byte address", 32'(wlog_addr[wbase & 63]), 32'h4000);
        wbase = wcnt;
        run_frame(16'h0042, {5'd4, 1'b1, 2'b00}, 1, 8'h77);
        check(wcnt == wbase + 1, "R8 fresh frame count", 32'(wcnt - wbase), 1);
        check(wlog_addr[wbase & 63] == 16'h0042, "R8 fresh header address", 32'(wlog_addr[wbase & 63]), 32'h42);
        check(wlog_blk[wbase & 63] == 5'd4, "R8 fresh header block", 32'(wlog_blk[wbase & 63]), 4);
        check(wlog_data[wbase & 63] == 8'h77, "R8 fresh data", 32'(wlog_data[wbase & 63]), 32'h77);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule